// File: doc/BRIEF.md
# Selectable Serial CRC Engine with Per-Character Inclusion

This block generates and checks a 16-bit CRC on a synchronous receive bit stream, one bit per `bit_valid` strobe. It offers two polynomials, CRC-16 (x^16+x^15+x^2+1) and CCITT (x^16+x^12+x^5+1). Both run in reflected form, least significant bit first. The register is preset to all zeros or all ones when a frame begins. The polynomial, the preset and the operating mode are captured at that moment and held for the whole frame.

In byte-oriented mode, received bits pass through a one-character delay line before they reach the CRC register. This gives the host time to inspect each character and decide whether it counts toward the CRC. The decision is taken on the `incl` input once per character and applies to all eight bits of that character. In bit-oriented mode the delay is bypassed, every bit enters the CRC, and the CCITT polynomial is used whatever `poly_sel` says.

`crc_good` reports a valid remainder at the end of a frame. In byte-oriented mode, the last frame character leaves the delay only when one more character has been shifted in after it, such as a pad character.

Top module: `crcsel_engine`

## Requirements
- R1: After reset, `crc_out` is 0x0000 and `crc_good` is 0.
- R2: A cycle with `frame_start` high loads `crc_out` with 0xFFFF when `preset_ones` is 1, and with 0x0000 when it is 0. It clears `crc_good`. A `bit_valid` in the same cycle is discarded.
- R3: With `poly_sel`=0 in byte mode (`mode_bit`=0), each consumed bit updates the register as follows: fb = crc[0] xor bit, then crc = (crc >> 1) xor (fb ? 0xA001 : 0).
- R4: With `poly_sel`=1, the same update uses the constant 0x8408 (CCITT).
- R5: In bit mode (`mode_bit`=1), each valid bit changes `crc_out` on the clock edge that samples it, with no delay.
- R6: In byte mode, the first 8 valid bits after `frame_start` leave `crc_out` unchanged. The bit received k valid bits earlier is consumed together with valid bit k+8.
- R7: In byte mode, `incl` is sampled on the valid bit that carries a delayed character's first bit out of the delay line. If it is 0, the CRC register keeps its value for all 8 bits of that character. `incl` has no effect on the other 7 bits.
- R8: Bit mode forces the CCITT polynomial regardless of `poly_sel`, and includes every bit regardless of `incl`.
- R9: `crc_good` is 1 when at least one bit has entered the CRC since the last `frame_start` and `crc_out` equals the residue. The residue is 0xF0B8 for CCITT with an all-ones preset, and 0x0000 in every other case.
- R10: `mode_bit`, `poly_sel` and `preset_ones` are sampled only in the `frame_start` cycle. Changing them mid-frame has no effect.
- R11: A cycle with neither `frame_start` nor `bit_valid` leaves `crc_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Presets the CRC and captures the frame settings |
| preset_ones | input | 1 | 1: all-ones preset, 0: all-zeros preset |
| mode_bit | input | 1 | 1: bit-oriented mode, 0: byte-oriented mode |
| poly_sel | input | 1 | 0: CRC-16, 1: CCITT (byte mode only) |
| bit_valid | input | 1 | Strobe that qualifies `bit_in` |
| bit_in | input | 1 | Received serial data bit |
| incl | input | 1 | Include decision for the character leaving the delay |
| crc_out | output | 16 | Current CRC register |
| crc_good | output | 1 | Remainder matches the residue |

## Verification
The CRC is driven with multi-byte data under each polynomial and in each mode. The same bytes sent with `poly_sel`=0 in bit mode must give the CCITT result, which separates a forced polynomial from a selected one. Byte-mode runs check the register at exactly 8 and 9 bits, which pins the delay length. A run that excludes one middle character, while toggling `incl` on its other bits, tells per-character sampling apart from per-bit gating. Frames that end in a valid FCS (complemented CCITT, plain CRC-16 plus a pad character), along with a corrupted one, exercise both residues of the good flag.

// File: rtl/crcsel_pkg.sv
package crcsel_pkg;

    localparam int CRC_W = 16;

    localparam logic [CRC_W-1:0] POLY_CRC16_REFL = 16'hA001;
    localparam logic [CRC_W-1:0] POLY_CCITT_REFL = 16'h8408;
    localparam logic [CRC_W-1:0] RESIDUE_CCITT_ONES = 16'hF0B8;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_BIT  = 1'b1
    } crc_mode_e;

    // one reflected (LSB first) shift step
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = cur[0] ^ din;
        return (cur >> 1) ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crcsel_delay.sv
module crcsel_delay #(
    parameter int CHAR_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    input  logic din,
    output logic dout,
    output logic full,
    output logic char_first
);

    localparam int CNT_W = $clog2(CHAR_W + 1);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] line;
        logic [CNT_W-1:0]  fill;
        logic [CNT_W-1:0]  pos;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (shift) begin
            st_d.line = {din, st_q.line[CHAR_W-1:1]};
            st_d.pos  = (st_q.pos == POS_LAST) ? '0 : st_q.pos + 1'b1;
            if (st_q.fill != FILL_MAX) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.line[0];
    assign full       = (st_q.fill == FILL_MAX);
    assign char_first = (st_q.pos == '0);

endmodule

// File: rtl/crcsel_core.sv
module crcsel_core
    import crcsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CRC_W-1:0] load_val,
    input  logic             step,
    input  logic             din,
    input  logic [CRC_W-1:0] poly,
    output logic [CRC_W-1:0] crc
);

    typedef struct packed {
        logic [CRC_W-1:0] reg_v;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.reg_v = load_val;
        end else if (step) begin
            st_d.reg_v = crc_step(st_q.reg_v, din, poly);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.reg_v;

endmodule

// File: rtl/crcsel_engine.sv
module crcsel_engine
    import crcsel_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        preset_ones,
    input  logic        mode_bit,
    input  logic        poly_sel,
    input  logic        bit_valid,
    input  logic        bit_in,
    input  logic        incl,
    output logic [15:0] crc_out,
    output logic        crc_good
);

    typedef struct packed {
        crc_mode_e mode;
        logic      ccitt;
        logic      ones;
        logic      keep;
        logic      seen;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic             dly_out, dly_full, dly_first;
    logic             byte_shift, dly_emit, incl_now;
    logic             crc_step_en, crc_din;
    logic [CRC_W-1:0] poly_w, preset_w, residue_w, crc_w;

    always_comb begin
        st_d       = st_q;
        byte_shift = !frame_start && bit_valid && (st_q.mode == MODE_BYTE);
        dly_emit   = byte_shift && dly_full;
        incl_now   = dly_first ? incl : st_q.keep;

        if (st_q.mode == MODE_BIT) begin
            crc_step_en = !frame_start && bit_valid;
            crc_din     = bit_in;
        end else begin
            crc_step_en = dly_emit && incl_now;
            crc_din     = dly_out;
        end

        if (frame_start) begin
            st_d.mode  = crc_mode_e'(mode_bit);
            st_d.ccitt = mode_bit | poly_sel;
            st_d.ones  = preset_ones;
            st_d.keep  = 1'b0;
            st_d.seen  = 1'b0;
        end else begin
            if (dly_emit && dly_first) begin
                st_d.keep = incl;
            end
            if (crc_step_en) begin
                st_d.seen = 1'b1;
            end
        end

        poly_w    = st_q.ccitt ? POLY_CCITT_REFL : POLY_CRC16_REFL;
        preset_w  = preset_ones ? '1 : '0;
        residue_w = (st_q.ccitt && st_q.ones) ? RESIDUE_CCITT_ONES : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_BYTE, ccitt: 1'b0, ones: 1'b0, keep: 1'b0, seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    crcsel_delay #(.CHAR_W(CHAR_W)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (frame_start),
        .shift      (byte_shift),
        .din        (bit_in),
        .dout       (dly_out),
        .full       (dly_full),
        .char_first (dly_first)
    );

    crcsel_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .load_val (preset_w),
        .step     (crc_step_en),
        .din      (crc_din),
        .poly     (poly_w),
        .crc      (crc_w)
    );

    assign crc_out  = crc_w;
    assign crc_good = st_q.seen && (crc_w == residue_w);

endmodule

// File: rtl/crcsel_engine_chk.sv
module crcsel_engine_chk #(
    parameter int CHAR_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_start,
    input logic        preset_ones,
    input logic        mode_bit,
    input logic        bit_valid,
    input logic [15:0] crc_out,
    input logic        crc_good
);

    localparam int VC_W = $clog2(CHAR_W + 1);
    localparam logic [VC_W-1:0] VC_MAX = VC_W'(CHAR_W);

    logic            byte_q;
    logic [VC_W-1:0] vcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= 1'b1;
            vcnt_q <= '0;
        end else if (frame_start) begin
            byte_q <= !mode_bit;
            vcnt_q <= '0;
        end else if (bit_valid && vcnt_q != VC_MAX) begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    // R2
    a_r2_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (crc_out == ($past(preset_ones) ? 16'hFFFF : 16'h0000)));

    // R2 / R9
    a_r9_start_clears_good: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !crc_good);

    // R11
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !bit_valid) |=> $stable(crc_out));

    // R6
    a_r6_delay_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && bit_valid && byte_q && vcnt_q != VC_MAX) |=> $stable(crc_out));

    // R9
    a_r9_good_residue: assert property (@(posedge clk) disable iff (!rst_n)
        crc_good |-> (crc_out == 16'hF0B8 || crc_out == 16'h0000));

endmodule

bind crcsel_engine crcsel_engine_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .preset_ones (preset_ones),
    .mode_bit    (mode_bit),
    .bit_valid   (bit_valid),
    .crc_out     (crc_out),
    .crc_good    (crc_good)
);

// File: tb/crcsel_engine_tb.sv
module crcsel_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        preset_ones = 1'b0;
    logic        mode_bit = 1'b0;
    logic        poly_sel = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        incl = 1'b0;
    logic [15:0] crc_out;
    logic        crc_good;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crcsel_engine u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .preset_ones(preset_ones), .mode_bit(mode_bit), .poly_sel(poly_sel),
        .bit_valid(bit_valid), .bit_in(bit_in), .incl(incl),
        .crc_out(crc_out), .crc_good(crc_good)
    );

    function automatic logic [15:0] m_bit(input logic [15:0] c, input logic b, input logic cc);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? (cc ? 16'h8408 : 16'hA001) : 16'h0000);
    endfunction

    function automatic logic [15:0] m_byte(input logic [15:0] c, input logic [7:0] d, input logic cc);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = m_bit(r, d[i], cc);
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic ones, input logic bm, input logic ps);
        @(negedge clk);
        frame_start = 1'b1; preset_ones = ones; mode_bit = bm; poly_sel = ps;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic i);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = b; incl = i;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    // incl is driven to inc on bit 0 and to its complement on bits 1..7
    task automatic send_char(input logic [7:0] d, input logic inc);
        for (int i = 0; i < 8; i++) send_bit(d[i], (i == 0) ? inc : !inc);
    endtask

    task automatic t_reset;
        chk("R1 crc after reset", crc_out, 16'h0000);
        chk("R1 good after reset", {15'd0, crc_good}, 16'd0);
    endtask

    task automatic t_preset;
        start(1'b1, 1'b0, 1'b0);
        chk("R2 ones preset", crc_out, 16'hFFFF);
        chk("R2 good cleared", {15'd0, crc_good}, 16'd0);
        @(negedge clk);
        frame_start = 1'b1; preset_ones = 1'b0; mode_bit = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; bit_valid = 1'b0;
        chk("R2 zero preset beats bit_valid", crc_out, 16'h0000);
    endtask

    task automatic t_bitmode;
        logic [15:0] m;
        start(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        m = m_bit(16'hFFFF, 1'b1, 1'b1);
        chk("R5 bit consumed at once", crc_out, m);
        for (int i = 1; i < 8; i++) m = m_bit(m, 1'b0, 1'b1);
        for (int i = 1; i < 8; i++) send_bit(1'b0, 1'b0);
        send_char(8'h31, 1'b0);
        m = m_byte(m, 8'h31, 1'b1);
        chk("R8 forced CCITT, incl ignored", crc_out, m);
        bit_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 idle hold", crc_out, m);
    endtask

    task automatic t_crc16_byte;
        logic [15:0] m;
        start(1'b0, 1'b0, 1'b0);
        send_char(8'h5A, 1'b1);
        chk("R6 nothing in first 8 bits", crc_out, 16'h0000);
        send_bit(1'b1, 1'b1);
        m = m_bit(16'h0000, 1'b0, 1'b0);
        chk("R6 ninth bit pulls first bit", crc_out, m);
        for (int i = 1; i < 8; i++) send_bit(1'b1, 1'b1);
        send_char(8'h7E, 1'b1);
        m = m_byte(m_byte(16'h0000, 8'h5A, 1'b0), 8'hFF, 1'b0);
        chk("R3 crc16 byte mode", crc_out, m);
    endtask

    task automatic t_ccitt_byte;
        logic [15:0] m;
        start(1'b1, 1'b0, 1'b1);
        send_char(8'hA5, 1'b1);
        send_char(8'h3C, 1'b1);
        send_char(8'h00, 1'b1);
        m = m_byte(m_byte(16'hFFFF, 8'hA5, 1'b1), 8'h3C, 1'b1);
        chk("R4 ccitt byte mode", crc_out, m);
    endtask

    task automatic t_exclude;
        logic [15:0] m;
        start(1'b1, 1'b0, 1'b1);
        send_char(8'h11, 1'b1);
        send_char(8'h22, 1'b1);
        send_char(8'h33, 1'b0);
        m = m_byte(16'hFFFF, 8'h11, 1'b1);
        chk("R7 excluded char held", crc_out, m);
        send_char(8'h44, 1'b1);
        m = m_byte(m, 8'h33, 1'b1);
        chk("R7 next char included", crc_out, m);
    endtask

    task automatic t_good_ccitt;
        logic [15:0] m, f;
        start(1'b1, 1'b1, 1'b0);
        send_char(8'hC1, 1'b0);
        send_char(8'h07, 1'b0);
        m = m_byte(m_byte(16'hFFFF, 8'hC1, 1'b1), 8'h07, 1'b1);
        f = ~m;
        for (int i = 0; i < 16; i++) send_bit(f[i], 1'b0);
        chk("R9 ccitt residue", crc_out, 16'hF0B8);
        chk("R9 good high", {15'd0, crc_good}, 16'd1);
        start(1'b1, 1'b1, 1'b0);
        send_char(8'hC1, 1'b0);
        send_char(8'h07, 1'b0);
        f = ~m ^ 16'h0100;
        for (int i = 0; i < 16; i++) send_bit(f[i], 1'b0);
        chk("R9 corrupted fcs not good", {15'd0, crc_good}, 16'd0);
    endtask

    task automatic t_good_crc16;
        logic [15:0] m;
        start(1'b0, 1'b0, 1'b0);
        send_char(8'h9D, 1'b1);
        send_char(8'h42, 1'b1);
        m = m_byte(m_byte(16'h0000, 8'h9D, 1'b0), 8'h42, 1'b0);
        send_char(m[7:0], 1'b1);
        send_char(m[15:8], 1'b1);
        send_char(8'hFF, 1'b1);
        chk("R9 crc16 zero residue", crc_out, 16'h0000);
        chk("R9 crc16 good", {15'd0, crc_good}, 16'd1);
    endtask

    task automatic t_latch;
        logic [15:0] m;
        start(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        poly_sel = 1'b1; mode_bit = 1'b1; preset_ones = 1'b1;
        send_char(8'hE4, 1'b1);
        send_char(8'h19, 1'b1);
        send_char(8'h00, 1'b1);
        m = m_byte(m_byte(16'h0000, 8'hE4, 1'b0), 8'h19, 1'b0);
        chk("R10 settings held mid-frame", crc_out, m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_preset();
        t_bitmode();
        t_crc16_byte();
        t_ccitt_byte();
        t_exclude();
        t_good_ccitt();
        t_good_crc16();
        t_latch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule